// File: doc/BRIEF.md
# Four-Channel Converter Control Register File

This block is the software-visible register file of a four-channel analog-to-digital conversion controller. A host reaches it over a plain 32-bit word bus with a single select, a write flag, a byte address and separate write and read data. It stores two 32-bit configuration words for each logical channel (A to D), a timer-unit word, a global core word and two interrupt enable words. It also keeps a status word of per-channel completion and timeout flags, and two packed result words.

A conversion sequencer outside the block reports events through strobes. These are a completion strobe with a channel index and a 12-bit result, and a timeout strobe that uses the same channel index. A completion writes the result into its half of a shared result word and raises the channel's completion flag. A timeout raises the channel's timeout flag. Flags stay set until software writes a zero to them. Reading them never clears them. One interrupt line goes high while any flag is set that both enable words allow. Addresses that map to no register read as zero, and writes to them have no effect.

Reads are served by a two-state response machine. `BUS_IDLE` moves to `BUS_RDATA` when a read is requested. `BUS_RDATA` stays in `BUS_RDATA` if a new read is requested in the same cycle, and returns to `BUS_IDLE` otherwise. Writes take effect at the clock edge that samples them and do not change the state.

Top module: `adc_ctrl_regs`

## Requirements
- R1: After reset, every channel word, the timer word, both enable words, the status word and both result words read 0. The global word reads 0x8000_0002. `irq` and `bus_rvalid` are low.
- R2: Channel n (0..3) has its first configuration word at byte offset 0x20*n and its second at 0x20*n+0x10. All 32 bits of each word can be written and read back.
- R3: The timer-unit word (0x90), the signal-enable word (0xC0) and the interrupt-enable word (0xD0) are full 32-bit read/write words.
- R4: The global word at 0x130 stores only bit 31 (clock gate), bit 1 (power down) and bit 0 (core enable). Its other bits read 0.
- R5: A read sampled at a clock edge raises `bus_rvalid` for the following cycle, with `bus_rdata` holding the register value from before that edge. Reads in consecutive cycles give consecutive valid cycles. `bus_rvalid` is low when no read was sampled at the previous edge.
- R6: A completion strobe with index c stores the result in word 0xF0 (c=0 in bits 11:0, c=1 in bits 27:16) or in word 0x100 (c=2 in bits 11:0, c=3 in bits 27:16), and sets status bit 8+c at the same edge. Other result fields keep their values.
- R7: A timeout strobe with index c sets status bit 16+c.
- R8: Writing the status word (0xE0) clears each implemented bit that is written as 0 and keeps each bit that is written as 1. A read does not clear any bit. Only bits 8..11 and 16..19 are implemented; all other bits read 0.
- R9: If a strobe sets a status bit in the same cycle that a status write writes 0 to that bit, the bit ends up set.
- R10: `irq` is high exactly when some status bit is also set in both the interrupt-enable and signal-enable words.
- R11: A misaligned address (low two bits not 00), any address above 0x130, and the unmapped words (0x80, 0xA0, 0xB0, 0x110, 0x120) read 0 and ignore writes. The result words ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (9) | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while bus_rvalid |
| bus_rvalid | output | 1 | Read data valid |
| cnv_done | input | 1 | Conversion-complete strobe |
| cnv_tmo | input | 1 | Conversion-timeout strobe |
| cnv_ch | input | 2 | Channel index for both strobes |
| cnv_result | input | RES_W (12) | Conversion result carried with cnv_done |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that the strobes are single-cycle events whose channel index is valid whenever either strobe is high. They also assume that the bus carries at most one access per cycle, either a read or a write. The bench drives every strobe and bus request for exactly one cycle, changes inputs only at the falling edge, and keeps the channel index within 0..3. The only collision it creates on purpose is a status write together with a strobe, which tests the priority of setting over clearing.

// File: rtl/adc_regmap_pkg.sv
package adc_regmap_pkg;

    localparam int NUM_CH     = 4;
    localparam int DATA_W     = 32;
    localparam int CH_STRIDE  = 'h20;
    localparam int CFG2_OFS   = 'h10;
    localparam int OFS_CH_END = 'h80;
    localparam int OFS_TIMER  = 'h90;
    localparam int OFS_SIGEN  = 'hC0;
    localparam int OFS_INTEN  = 'hD0;
    localparam int OFS_STAT   = 'hE0;
    localparam int OFS_RES_LO = 'hF0;
    localparam int OFS_RES_HI = 'h100;
    localparam int OFS_GCFG   = 'h130;

    localparam int DONE_LSB   = 8;
    localparam int TMO_LSB    = 16;
    localparam int HALF_LSB   = 16;
    localparam int NUM_PAIRS  = NUM_CH / 2;

    localparam logic [DATA_W-1:0] GCFG_MASK = 32'h8000_0003;
    localparam logic [DATA_W-1:0] GCFG_RST  = 32'h8000_0002;
    localparam logic [DATA_W-1:0] STAT_MASK =
        (DATA_W'((1 << NUM_CH) - 1) << DONE_LSB) |
        (DATA_W'((1 << NUM_CH) - 1) << TMO_LSB);

    typedef enum logic {
        BUS_IDLE,
        BUS_RDATA
    } bus_state_t;

    typedef enum logic [3:0] {
        RG_NONE,
        RG_CFG1,
        RG_CFG2,
        RG_TIMER,
        RG_SIGEN,
        RG_INTEN,
        RG_STAT,
        RG_RES,
        RG_GCFG
    } reg_sel_t;

    typedef struct packed {
        reg_sel_t    sel;
        logic [1:0]  idx;
    } reg_dec_t;

endpackage

// File: rtl/adc_addr_decode.sv
module adc_addr_decode
    import adc_regmap_pkg::*;
#(
    parameter int ADDR_W = 9
) (
    input  logic [ADDR_W-1:0] addr_i,
    output reg_dec_t          dec_o
);

    localparam logic [ADDR_W-1:0] A_CH_END = ADDR_W'(OFS_CH_END);
    localparam logic [ADDR_W-1:0] A_TIMER  = ADDR_W'(OFS_TIMER);
    localparam logic [ADDR_W-1:0] A_SIGEN  = ADDR_W'(OFS_SIGEN);
    localparam logic [ADDR_W-1:0] A_INTEN  = ADDR_W'(OFS_INTEN);
    localparam logic [ADDR_W-1:0] A_STAT   = ADDR_W'(OFS_STAT);
    localparam logic [ADDR_W-1:0] A_RES_LO = ADDR_W'(OFS_RES_LO);
    localparam logic [ADDR_W-1:0] A_RES_HI = ADDR_W'(OFS_RES_HI);
    localparam logic [ADDR_W-1:0] A_GCFG   = ADDR_W'(OFS_GCFG);

    always_comb begin
        dec_o.sel = RG_NONE;
        dec_o.idx = 2'd0;
        if (addr_i[1:0] != 2'b00) begin
            dec_o.sel = RG_NONE;
        end else if (addr_i < A_CH_END) begin
            if (addr_i[3:2] == 2'b00) begin
                dec_o.sel = addr_i[4] ? RG_CFG2 : RG_CFG1;
                dec_o.idx = addr_i[6:5];
            end
        end else begin
            unique case (addr_i)
                A_TIMER:  dec_o.sel = RG_TIMER;
                A_SIGEN:  dec_o.sel = RG_SIGEN;
                A_INTEN:  dec_o.sel = RG_INTEN;
                A_STAT:   dec_o.sel = RG_STAT;
                A_RES_LO: begin dec_o.sel = RG_RES; dec_o.idx = 2'd0; end
                A_RES_HI: begin dec_o.sel = RG_RES; dec_o.idx = 2'd1; end
                A_GCFG:   dec_o.sel = RG_GCFG;
                default:  dec_o.sel = RG_NONE;
            endcase
        end
    end

endmodule

// File: rtl/adc_bus_fsm.sv
module adc_bus_fsm
    import adc_regmap_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_req_i,
    input  logic [DATA_W-1:0] rd_mux_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              rvalid_o
);

    bus_state_t state_q, state_d;
    logic [DATA_W-1:0] rdata_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BUS_IDLE:  state_d = rd_req_i ? BUS_RDATA : BUS_IDLE;
            BUS_RDATA: state_d = rd_req_i ? BUS_RDATA : BUS_IDLE;
            default:   state_d = BUS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= BUS_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        rdata_q <= '0;
        else if (rd_req_i) rdata_q <= rd_mux_i;
    end

    assign rdata_o  = rdata_q;
    assign rvalid_o = (state_q == BUS_RDATA);

    // R5
    rd_valid_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_i |=> rvalid_o);

    // R5
    no_spurious_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req_i |=> !rvalid_o);

endmodule

// File: rtl/adc_status_reg.sv
module adc_status_reg
    import adc_regmap_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              done_i,
    input  logic              tmo_i,
    input  logic [1:0]        ch_i,
    input  logic [DATA_W-1:0] inten_i,
    input  logic [DATA_W-1:0] sigen_i,
    output logic [DATA_W-1:0] stat_o,
    output logic              irq_o
);

    logic [DATA_W-1:0] stat_q, stat_d, keep_v, set_v;

    always_comb begin
        set_v = '0;
        if (done_i) set_v[DONE_LSB + int'(ch_i)] = 1'b1;
        if (tmo_i)  set_v[TMO_LSB + int'(ch_i)]  = 1'b1;
    end

    always_comb begin
        keep_v = we_i ? (stat_q & wdata_i) : stat_q;
        stat_d = (keep_v | set_v) & STAT_MASK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= stat_d;
    end

    assign stat_o = stat_q;
    assign irq_o  = |(stat_q & inten_i & sigen_i);

    // R9
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_v != '0) |=> ((stat_q & $past(set_v)) == $past(set_v)));

    // R8
    read_no_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !we_i |=> ((stat_q & $past(stat_q)) == $past(stat_q)));

    // R8
    one_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && (wdata_i == '1)) |=> ((stat_q & $past(stat_q)) == $past(stat_q)));

    // R10
    irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (stat_q != '0));

endmodule

// File: rtl/adc_result_store.sv
module adc_result_store
    import adc_regmap_pkg::*;
#(
    parameter int RES_W = 12
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              done_i,
    input  logic [1:0]                        ch_i,
    input  logic [RES_W-1:0]                  result_i,
    output logic [NUM_PAIRS-1:0][DATA_W-1:0]  words_o
);

    logic [NUM_CH-1:0][RES_W-1:0] field_q;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_field
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                field_q[c] <= '0;
            else if (done_i && (int'(ch_i) == c))      field_q[c] <= result_i;
        end

        // R6
        field_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (done_i && (int'(ch_i) == c)) |=> (field_q[c] == $past(result_i)));
    end

    for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
        always_comb begin
            words_o[p] = '0;
            words_o[p][RES_W-1:0]             = field_q[2*p];
            words_o[p][HALF_LSB +: RES_W]     = field_q[2*p+1];
        end
    end

    // R6
    fields_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done_i |=> $stable(field_q));

endmodule

// File: rtl/adc_ctrl_regs.sv
module adc_ctrl_regs
    import adc_regmap_pkg::*;
#(
    parameter int ADDR_W = 9,
    parameter int RES_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              bus_rvalid,
    input  logic              cnv_done,
    input  logic              cnv_tmo,
    input  logic [1:0]        cnv_ch,
    input  logic [RES_W-1:0]  cnv_result,
    output logic              irq
);

    reg_dec_t dec;
    logic     rd_req, wr_req;
    logic [DATA_W-1:0] rd_mux;

    logic [NUM_CH-1:0][DATA_W-1:0]    cfg1_q, cfg2_q;
    logic [DATA_W-1:0]                timer_q, sigen_q, inten_q, gcfg_q, stat;
    logic [NUM_PAIRS-1:0][DATA_W-1:0] res_words;

    assign rd_req = bus_sel && !bus_wr;
    assign wr_req = bus_sel &&  bus_wr;

    adc_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr_i (bus_addr),
        .dec_o  (dec)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chcfg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cfg1_q[c] <= '0;
                cfg2_q[c] <= '0;
            end else if (wr_req && (int'(dec.idx) == c)) begin
                if (dec.sel == RG_CFG1) cfg1_q[c] <= bus_wdata;
                if (dec.sel == RG_CFG2) cfg2_q[c] <= bus_wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            timer_q <= '0;
            sigen_q <= '0;
            inten_q <= '0;
            gcfg_q  <= GCFG_RST;
        end else if (wr_req) begin
            if (dec.sel == RG_TIMER) timer_q <= bus_wdata;
            if (dec.sel == RG_SIGEN) sigen_q <= bus_wdata;
            if (dec.sel == RG_INTEN) inten_q <= bus_wdata;
            if (dec.sel == RG_GCFG)  gcfg_q  <= bus_wdata & GCFG_MASK;
        end
    end

    adc_status_reg u_stat (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (wr_req && (dec.sel == RG_STAT)),
        .wdata_i (bus_wdata),
        .done_i  (cnv_done),
        .tmo_i   (cnv_tmo),
        .ch_i    (cnv_ch),
        .inten_i (inten_q),
        .sigen_i (sigen_q),
        .stat_o  (stat),
        .irq_o   (irq)
    );

    adc_result_store #(.RES_W(RES_W)) u_res (
        .clk      (clk),
        .rst_n    (rst_n),
        .done_i   (cnv_done),
        .ch_i     (cnv_ch),
        .result_i (cnv_result),
        .words_o  (res_words)
    );

    always_comb begin
        rd_mux = '0;
        unique case (dec.sel)
            RG_CFG1:  rd_mux = cfg1_q[dec.idx];
            RG_CFG2:  rd_mux = cfg2_q[dec.idx];
            RG_TIMER: rd_mux = timer_q;
            RG_SIGEN: rd_mux = sigen_q;
            RG_INTEN: rd_mux = inten_q;
            RG_STAT:  rd_mux = stat;
            RG_RES:   rd_mux = res_words[dec.idx[0]];
            RG_GCFG:  rd_mux = gcfg_q;
            default:  rd_mux = '0;
        endcase
    end

    adc_bus_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_req_i (rd_req),
        .rd_mux_i (rd_mux),
        .rdata_o  (bus_rdata),
        .rvalid_o (bus_rvalid)
    );

    // R4
    gcfg_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && dec.sel == RG_GCFG) |=> (gcfg_q == ($past(bus_wdata) & GCFG_MASK)));

    // R11
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && dec.sel == RG_NONE) |=> (bus_rdata == '0));

endmodule

// File: tb/sim_adc_ctrl_regs.sv
module sim_adc_ctrl_regs;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [8:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_rvalid;
    logic        cnv_done = 1'b0, cnv_tmo = 1'b0;
    logic [1:0]  cnv_ch = '0;
    logic [11:0] cnv_result = '0;
    logic        irq;

    int n_chk = 0, n_fail = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #10 clk = ~clk;

    adc_ctrl_regs u0 (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .cnv_done(cnv_done), .cnv_tmo(cnv_tmo),
        .cnv_ch(cnv_ch), .cnv_result(cnv_result), .irq(irq)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    // monitor: pops the scoreboard whenever read data is presented
    always @(negedge clk) begin
        if (rst_n && bus_rvalid) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R5 unexpected rvalid", 32'd1, 32'd0);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(bus_rdata === e, t, bus_rdata, e);
            end
        end
    end

    task automatic rd(input int a, input logic [31:0] e, input string t);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a[8:0];
        exp_q.push_back(e); tag_q.push_back(t);
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a[8:0]; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic strobe(input bit d, input bit t, input int c, input logic [11:0] r);
        @(negedge clk);
        cnv_done = d; cnv_tmo = t; cnv_ch = c[1:0]; cnv_result = r;
        @(negedge clk);
        cnv_done = 1'b0; cnv_tmo = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        chk(1'b0, "watchdog expired", 32'd0, 32'd1);
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(irq === 1'b0, "R1 irq after reset", {31'd0, irq}, 32'd0);
        chk(bus_rvalid === 1'b0, "R1 rvalid after reset", {31'd0, bus_rvalid}, 32'd0);
        rd('h00, 32'h0, "R1 cfg1 A reset");
        rd('h90, 32'h0, "R1 timer reset");
        rd('hE0, 32'h0, "R1 status reset");
        rd('hF0, 32'h0, "R1 result reset");
        rd('h130, 32'h8000_0002, "R1 global reset");

        // R2 channel words
        for (int c = 0; c < 4; c++) begin
            wr('h20*c, 32'hE000_0000 | (c << 24) | c);
            wr('h20*c + 'h10, 32'h0000_3000 + c);
        end
        for (int c = 0; c < 4; c++) begin
            rd('h20*c, 32'hE000_0000 | (c << 24) | c, "R2 cfg1 readback");
            rd('h20*c + 'h10, 32'h0000_3000 + c, "R2 cfg2 readback");
        end

        // R3 full-width words
        wr('h90, 32'h2000_0001);
        rd('h90, 32'h2000_0001, "R3 timer readback");
        wr('hC0, 32'hA5A5_5A5A);
        rd('hC0, 32'hA5A5_5A5A, "R3 sigen readback");
        wr('hD0, 32'h1234_5678);
        rd('hD0, 32'h1234_5678, "R3 inten readback");

        // R4 global word
        wr('h130, 32'hFFFF_FFFF);
        rd('h130, 32'h8000_0003, "R4 global masked");
        wr('h130, 32'h0000_0001);
        rd('h130, 32'h0000_0001, "R4 global core enable only");

        // R5 back-to-back reads then idle
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 9'h090;
        exp_q.push_back(32'h2000_0001); tag_q.push_back("R5 first of pair");
        @(negedge clk);
        bus_addr = 9'h130;
        exp_q.push_back(32'h0000_0001); tag_q.push_back("R5 second of pair");
        @(negedge clk);
        bus_sel = 1'b0;
        @(negedge clk);
        chk(bus_rvalid === 1'b0, "R5 rvalid drops", {31'd0, bus_rvalid}, 32'd0);

        // clear enables for the interrupt tests later
        wr('hC0, 32'h0);
        wr('hD0, 32'h0);

        // R6 results and completion flags
        strobe(1'b1, 1'b0, 0, 12'h5A5);
        strobe(1'b1, 1'b0, 1, 12'hABC);
        rd('hF0, 32'h0ABC_05A5, "R6 pair A/B");
        strobe(1'b1, 1'b0, 2, 12'h123);
        strobe(1'b1, 1'b0, 3, 12'hFFF);
        rd('h100, 32'h0FFF_0123, "R6 pair C/D");
        rd('hF0, 32'h0ABC_05A5, "R6 other pair kept");
        rd('hE0, 32'h0000_0F00, "R6 done flags");
        rd('hE0, 32'h0000_0F00, "R8 read does not clear");

        // R7 timeout
        strobe(1'b0, 1'b1, 2, 12'h000);
        rd('hE0, 32'h0004_0F00, "R7 timeout flag");
        rd('h100, 32'h0FFF_0123, "R7 timeout leaves result");

        // R8 write-zero clear
        wr('hE0, 32'hFFFF_F0FF);
        rd('hE0, 32'h0004_0000, "R8 zero clears done bits");
        wr('hE0, 32'hFFFF_FFFF);
        rd('hE0, 32'h0004_0000, "R8 ones keep bits");

        // R11 ignored accesses
        wr('hF0, 32'h0);
        rd('hF0, 32'h0ABC_05A5, "R11 result write ignored");
        wr('h92, 32'h0);
        rd('h90, 32'h2000_0001, "R11 misaligned write ignored");
        rd('h92, 32'h0, "R11 misaligned read zero");
        rd('h134, 32'h0, "R11 above top reads zero");
        wr('h1F0, 32'hFFFF_FFFF);
        rd('h1F0, 32'h0, "R11 high address reads zero");
        rd('h130, 32'h0000_0001, "R11 high write no alias");
        rd('hA0, 32'h0, "R11 hole reads zero");
        rd('h80, 32'h0, "R11 hole 0x80 reads zero");

        // R10 interrupt (status holds bit 18)
        @(negedge clk);
        chk(irq === 1'b0, "R10 irq off with no enables", {31'd0, irq}, 32'd0);
        wr('hD0, 32'h0004_0000);
        chk(irq === 1'b0, "R10 irq off without signal enable", {31'd0, irq}, 32'd0);
        wr('hC0, 32'h0004_0000);
        chk(irq === 1'b1, "R10 irq on", {31'd0, irq}, 32'd1);
        wr('hE0, 32'h0);
        chk(irq === 1'b0, "R10 irq off after clear", {31'd0, irq}, 32'd0);

        // R9 set beats same-cycle clear
        strobe(1'b0, 1'b1, 1, 12'h000);
        rd('hE0, 32'h0002_0000, "R9 setup timeout B");
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 9'h0E0; bus_wdata = 32'h0;
        cnv_done = 1'b1; cnv_ch = 2'd0; cnv_result = 12'h777;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; cnv_done = 1'b0;
        rd('hE0, 32'h0000_0100, "R9 set wins over clear");
        rd('hF0, 32'h0ABC_0777, "R9 result stored");

        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, "R5 all reads answered", exp_q.size(), 32'd0);
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule